// File: doc/BRIEF.md
# Programmable Prescaled Down-Counter Timer

This block is a 32-bit countdown timer on a small word-addressed register port. Software picks a clock divider, selects single-shot or auto-reload operation and writes a start value. The counter then steps down by one on every prescaler terminal event. When it steps down from 1 it expires and raises a one-cycle interrupt pulse. A mask bit silences that pulse while the count keeps running.

The counter is held in a three-state machine. IDLE means the counter is stopped at zero, which is the state after reset or after a zero start value. RUN means it is counting. DONE means a single-shot expiry has happened and the count is parked at zero.

The transitions are as follows:
- load-nonzero: any state goes to RUN.
- load-zero: any state goes to IDLE.
- expire-reload: RUN stays in RUN when auto-reload is selected.
- expire-stop: RUN goes to DONE when single-shot is selected.
- DONE is left only by a new load.

Top module: `cdtimer`

## Requirements
- R1: After reset every register reads zero, the interrupt output is low and the timer is in IDLE.
- R2: Word address 0 is the mode register: bit 17 selects auto-reload (1) or single-shot (0), bit 16 is the interrupt mask, bits 7:0 hold a stored vector number, and all other bits read 0. Address 1 is the start value and is readable and writable. Address 2 returns the live count and ignores writes. Address 3 keeps the low 4 bits of the divide code and reads 0 above them.
- R3: Divide codes map as follows: 0x0→2, 0x1→4, 0x2→8, 0x3→16, 0x8→32, 0x9→64, 0xA→128 and 0xB→1. Bit 2 of the code is ignored. While in RUN the count falls by exactly one every D cycles, where D is the divisor. The first step comes D cycles after the edge that loaded it.
- R4: A write to the start value copies it into the counter and restarts the prescaler at once. A write to the divide code also restarts the prescaler.
- R5: An expiry drives the interrupt output high for exactly the one cycle that follows the expiring edge, unless the mask bit is set.
- R6: In single-shot operation the count stays at zero after expiry and no further interrupt is raised until the next load.
- R7: In auto-reload operation the count returns to the start value at expiry and keeps counting, giving one interrupt every N·D cycles for a start value N.
- R8: A start value of zero stops the counter at zero, and no interrupt follows.
- R9: With the mask bit set the count keeps running and reloading, but the interrupt output stays low.
- R10: A start value of 1 expires on the first prescaler event, D cycles after the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | 1 | Expiry interrupt pulse |

## Verification
The assertions assume the following about the bus:
- bus_wr, bus_addr and bus_wdata are stable around each rising edge.
- At most one register is written per cycle.

The bench drives every input on the falling edge and holds it for a whole cycle. It parks bus_addr on the count register whenever it is not writing, so the live count can be compared on every clock against a behavioural model. The bench never rewrites the mode register in the same cycle as an expiry, so the mask value seen at that expiry is never in doubt.

// File: rtl/cdtimer_pkg.sv
package cdtimer_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 2;
    localparam int unsigned CODE_W   = 4;
    localparam int unsigned IDX_W    = 3;
    localparam int unsigned PRE_W    = 7;
    localparam int unsigned VEC_W    = 8;
    localparam int unsigned BIT_AUTO = 17;
    localparam int unsigned BIT_MASK = 16;

    localparam logic [ADDR_W-1:0] A_MODE  = 2'd0;
    localparam logic [ADDR_W-1:0] A_START = 2'd1;
    localparam logic [ADDR_W-1:0] A_LIVE  = 2'd2;
    localparam logic [ADDR_W-1:0] A_DIV   = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tmr_state_t;
endpackage

// File: rtl/cdtimer_prescale.sv
module cdtimer_prescale
    import cdtimer_pkg::*;
#(
    parameter int unsigned PW = PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             restart_i,
    output logic             tick_o
);
    logic [PW-1:0] pcnt_q;
    logic [IDX_W-1:0] shamt;
    logic [PW:0]   lim_w;
    logic [PW-1:0] lim;

    // divisor is 2^(idx+1) with the top index wrapping to 2^0
    assign shamt  = idx_i + 3'd1;
    assign lim_w  = ({{PW{1'b0}}, 1'b1} << shamt) - {{PW{1'b0}}, 1'b1};
    assign lim    = lim_w[PW-1:0];
    assign tick_o = (pcnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pcnt_q <= '0;
        else if (restart_i)  pcnt_q <= '0;
        else if (tick_o)     pcnt_q <= '0;
        else                 pcnt_q <= pcnt_q + 1'b1;
    end

    p_pcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= lim);
endmodule

// File: rtl/cdtimer_regs.sv
module cdtimer_regs
    import cdtimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] live_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] start_o,
    output logic              auto_o,
    output logic              mask_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              load_o,
    output logic              div_wr_o
);
    logic [VEC_W-1:0]  vec_q;
    logic [CODE_W-1:0] code_q;

    assign load_o   = wr_i && (addr_i == A_START);
    assign div_wr_o = wr_i && (addr_i == A_DIV);
    assign idx_o    = {code_q[3], code_q[1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q   <= '0;
            code_q  <= '0;
            start_o <= '0;
            auto_o  <= 1'b0;
            mask_o  <= 1'b0;
        end else if (wr_i) begin
            unique case (addr_i)
                A_MODE: begin
                    auto_o <= wdata_i[BIT_AUTO];
                    mask_o <= wdata_i[BIT_MASK];
                    vec_q  <= wdata_i[VEC_W-1:0];
                end
                A_START: start_o <= wdata_i;
                A_DIV:   code_q  <= wdata_i[CODE_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_MODE: begin
                rdata_o[BIT_AUTO]  = auto_o;
                rdata_o[BIT_MASK]  = mask_o;
                rdata_o[VEC_W-1:0] = vec_q;
            end
            A_START: rdata_o = start_o;
            A_LIVE:  rdata_o = live_i;
            A_DIV:   rdata_o[CODE_W-1:0] = code_q;
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/cdtimer_core.sv
module cdtimer_core
    import cdtimer_pkg::*;
#(
    parameter int unsigned CW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic [CW-1:0] start_i,
    input  logic          auto_i,
    input  logic          mask_i,
    input  logic          tick_i,
    output logic [CW-1:0] cnt_o,
    output logic          irq_o
);
    tmr_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          expire;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                if (tick_i) begin
                    if (cnt_q == {{(CW-1){1'b0}}, 1'b1}) begin
                        expire = 1'b1;
                        if (auto_i) begin
                            cnt_d = start_i;          // expire-reload
                        end else begin
                            cnt_d   = '0;             // expire-stop
                            state_d = ST_DONE;
                        end
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            ST_DONE: ;
            default: state_d = ST_IDLE;
        endcase
        if (load_i) begin
            expire  = 1'b0;
            cnt_d   = load_val_i;
            state_d = (load_val_i == '0) ? ST_IDLE : ST_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= expire && !mask_i;
    end

    assign cnt_o = cnt_q;

    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick_i && cnt_q > 1 && !load_i)
        |=> cnt_q == $past(cnt_q) - 1);

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i != '0) |=> (cnt_q == $past(load_val_i) && state_q == ST_RUN));

    p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !load_i) |=> (cnt_q == '0 && state_q == ST_DONE));

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick_i && cnt_q == 1 && auto_i && !load_i)
        |=> cnt_q == $past(start_i));

    p_zero_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i == '0) |=> (state_q == ST_IDLE && !irq_o));
endmodule

// File: rtl/cdtimer.sv
module cdtimer
    import cdtimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic [DATA_W-1:0] start_w, live_w;
    logic              auto_w, mask_w, load_w, div_wr_w, tick_w;
    logic [IDX_W-1:0]  idx_w;

    cdtimer_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .live_i   (live_w),
        .rdata_o  (bus_rdata),
        .start_o  (start_w),
        .auto_o   (auto_w),
        .mask_o   (mask_w),
        .idx_o    (idx_w),
        .load_o   (load_w),
        .div_wr_o (div_wr_w)
    );

    cdtimer_prescale #(.PW(PRE_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_i     (idx_w),
        .restart_i (load_w || div_wr_w),
        .tick_o    (tick_w)
    );

    cdtimer_core #(.CW(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_w),
        .load_val_i (bus_wdata),
        .start_i    (start_w),
        .auto_i     (auto_w),
        .mask_i     (mask_w),
        .tick_i     (tick_w),
        .cnt_o      (live_w),
        .irq_o      (irq_o)
    );

    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !$past(mask_w));

    p_live_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_LIVE && !tick_w) |=> $stable(live_w));
endmodule

// File: tb/sim_cdtimer.sv
module sim_cdtimer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    int irq_seen = 0;
    bit done = 1'b0;

    // behavioural model state
    logic [31:0] m_start = '0, m_cnt = '0;
    bit          m_auto = 0, m_mask = 0, m_run = 0, m_irq = 0;
    logic [3:0]  m_code = '0;
    int          m_pcnt = 0;

    cdtimer u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    function automatic int divisor(input logic [3:0] c);
        case (c & 4'b1011)
            4'h0: return 2;
            4'h1: return 4;
            4'h2: return 8;
            4'h3: return 16;
            4'h8: return 32;
            4'h9: return 64;
            4'hA: return 128;
            default: return 1;
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_start = '0; m_cnt = '0; m_auto = 0; m_mask = 0;
            m_run = 0; m_irq = 0; m_code = '0; m_pcnt = 0;
        end else begin
            int  d;
            bit  tk, ex;
            d  = divisor(m_code);
            tk = (m_pcnt == d - 1);
            ex = 0;
            if (bus_wr && bus_addr == 2'd1) begin
                m_start = bus_wdata;
                m_cnt   = bus_wdata;
                m_run   = (bus_wdata != 0);
            end else if (m_run && tk) begin
                if (m_cnt == 1) begin
                    ex = 1;
                    if (m_auto) m_cnt = m_start;
                    else begin m_cnt = 0; m_run = 0; end
                end else m_cnt = m_cnt - 1;
            end
            m_irq = ex && !m_mask;
            if (bus_wr && (bus_addr == 2'd1 || bus_addr == 2'd3)) m_pcnt = 0;
            else if (tk) m_pcnt = 0;
            else m_pcnt = m_pcnt + 1;
            if (bus_wr && bus_addr == 2'd0) begin
                m_auto = bus_wdata[17];
                m_mask = bus_wdata[16];
            end
            if (bus_wr && bus_addr == 2'd3) m_code = bus_wdata[3:0];
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            if (!bus_wr && bus_addr == 2'd2) check(bus_rdata, m_cnt, "R3 live count");
            check({31'b0, irq_o}, {31'b0, m_irq}, "R5 irq");
            if (irq_o) irq_seen++;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd2; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_addr = 2'd2;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v, v2;
        #1;
        check({31'b0, irq_o}, 32'd0, "R1 irq in reset");
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset values
        rd(2'd0, v); check(v, 32'h0, "R1 mode");
        rd(2'd1, v); check(v, 32'h0, "R1 start");
        rd(2'd2, v); check(v, 32'h0, "R1 live");
        rd(2'd3, v); check(v, 32'h0, "R1 divide");
        // R2 field layout and read-only live count
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); check(v, 32'h0003_00FF, "R2 mode fields");
        wr(2'd3, 32'hFFFF_FFF5);
        rd(2'd3, v); check(v, 32'h0000_0005, "R2 divide low bits");
        wr(2'd2, 32'h0000_0055);
        rd(2'd2, v); check(v, 32'h0, "R2 live ignores write");
        // single-shot, divide by 1
        wr(2'd0, 32'h0000_0021);
        wr(2'd3, 32'hB);
        irq_seen = 0;
        wr(2'd1, 32'd3);
        wait_cyc(20);
        check(irq_seen, 1, "R6 one expiry only");
        rd(2'd2, v); check(v, 32'h0, "R6 holds at zero");
        // R10 shortest timeout
        irq_seen = 0;
        wr(2'd1, 32'd1);
        wait_cyc(1);
        check({31'b0, irq_o}, 32'd1, "R10 expires after one cycle");
        wait_cyc(1);
        check({31'b0, irq_o}, 32'd0, "R5 pulse lasts one cycle");
        // R7 auto-reload, divide by 2
        wr(2'd3, 32'h0);
        wr(2'd0, 32'h0002_0000);
        irq_seen = 0;
        wr(2'd1, 32'd4);
        wait_cyc(38);
        check(irq_seen, 4, "R7 period N*D");
        // R9 mask keeps counting
        wr(2'd0, 32'h0003_0000);
        irq_seen = 0;
        rd(2'd2, v);
        wait_cyc(5);
        rd(2'd2, v2);
        wait_cyc(30);
        check(irq_seen, 0, "R9 masked no irq");
        check({31'b0, v != v2}, 32'd1, "R9 count still moves");
        // R8 zero start halts
        wr(2'd0, 32'h0002_0000);
        irq_seen = 0;
        wr(2'd1, 32'd0);
        wait_cyc(50);
        check(irq_seen, 0, "R8 no irq after zero");
        rd(2'd2, v); check(v, 32'h0, "R8 count stays zero");
        // R3 divide by 128
        wr(2'd0, 32'h0);
        wr(2'd3, 32'hA);
        irq_seen = 0;
        wr(2'd1, 32'd2);
        wait_cyc(250);
        check(irq_seen, 0, "R3 div128 not yet");
        wait_cyc(10);
        check(irq_seen, 1, "R3 div128 expired");
        // R3 bit 2 ignored: code 0x4 acts as divide by 2
        wr(2'd3, 32'h4);
        irq_seen = 0;
        wr(2'd1, 32'd3);
        wait_cyc(5);
        check(irq_seen, 0, "R3 code4 early");
        wait_cyc(2);
        check(irq_seen, 1, "R3 code4 as div2");
        // R4 restart mid-run, and divide write restarting prescaler
        wr(2'd3, 32'h1);
        wr(2'd1, 32'd50);
        wait_cyc(9);
        wr(2'd1, 32'd7);
        rd(2'd2, v); check(v, 32'd7, "R4 reload restarts count");
        wait_cyc(2);
        wr(2'd3, 32'h1);
        wait_cyc(40);
        finish_run();
    end
endmodule